// File: doc/BRIEF.md
# Dual-Rail Line Activity Monitor

This block watches a bipolar line pair whose levels arrive as four digitized comparator flags: a positive and a negative threshold flag for each of the two conductors. It counts a mark only when the two conductors swing in opposite directions at once and stay there for a minimum number of oversampling clocks. Same-direction swings, conflicting flags and short spikes are rejected as noise.

A bit-period strobe divides time into line bit slots. Every slot that ends without a qualified mark adds one to a run-of-zeros count. When that run reaches the limit (63 by default), a registered loss-of-activity flag is raised. The flag stays high for as long as the zeros continue. It drops at the first slot boundary after a qualified mark. The four flags are resynchronized to the oversampling clock before they are qualified.

Top module: `line_activity_mon`

## Requirements
- R1: A type-A condition (first conductor positive flag and second conductor negative flag high, the other two flags low) held for at least MIN_WIDTH (default 4) consecutive synchronized clocks is a qualified mark.
- R2: A type-B condition (first conductor negative flag and second conductor positive flag high, the other two flags low) held for at least MIN_WIDTH consecutive synchronized clocks is a qualified mark.
- R3: A type-A or type-B condition that lasts fewer than MIN_WIDTH clocks is not a mark, and its slot counts as a zero.
- R4: Both conductors flagged in the same direction, or any conductor flagged both ways at once, never forms a mark.
- R5: Each strobe that closes a slot with no qualified mark counts one zero. The strobe that closes the 63rd consecutive zero slot sets loss_o, which is visible in the cycle after that strobe edge. After 62 zero slots loss_o is still low.
- R6: The zero count saturates at ZERO_LIMIT and does not wrap, so loss_o stays high through any longer run of zeros.
- R7: A qualified mark restarts the zero run, so loss_o rises again only after 63 further zero slots.
- R8: After a qualified mark, loss_o stays as it was until the next strobe and then clears on that strobe.
- R9: A mark that qualifies in the same clock as a strobe belongs to the slot that the strobe closes. A mark that qualifies in the clock after the strobe belongs to the next slot.
- R10: The four flag inputs pass through SYNC_STAGES (default 2) flops before qualification. Reset (rst_ni low, asynchronous) clears the zero count, the width timers and loss_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_stb_i | input | 1 | One-clock pulse at each bit slot boundary |
| c0_pos_i | input | 1 | First conductor above positive threshold |
| c0_neg_i | input | 1 | First conductor below negative threshold |
| c1_pos_i | input | 1 | Second conductor above positive threshold |
| c1_neg_i | input | 1 | Second conductor below negative threshold |
| loss_o | output | 1 | Registered loss-of-activity flag |

## Verification
Two events can fall in the same clock: a mark reaching its width threshold, and the slot strobe. When they do, the slot must not count as a zero. The bench provokes this by starting a four-clock mark two clocks into an eight-clock slot, so that the mark qualifies exactly at the strobe edge. It then shifts the mark by one clock so that the mark qualifies just after the strobe. The outcome is judged at the port, cycle by cycle, against a behavioural model: loss_o must clear after the coincident case, and in the shifted case it must stay high for one more slot.

// File: rtl/line_mon_pkg.sv
package line_mon_pkg;
  typedef struct packed {
    logic c0_pos;
    logic c0_neg;
    logic c1_pos;
    logic c1_neg;
  } rail_t;

  localparam int unsigned NUM_MARK_TYPES = 2;

  // bit 0: type A, bit 1: type B; one-sided only, same polarity rejected
  function automatic logic [NUM_MARK_TYPES-1:0] mark_cond(rail_t r);
    logic [NUM_MARK_TYPES-1:0] c;
    c[0] = r.c0_pos & r.c1_neg & ~r.c0_neg & ~r.c1_pos;
    c[1] = r.c0_neg & r.c1_pos & ~r.c0_pos & ~r.c1_neg;
    return c;
  endfunction
endpackage

// File: rtl/lam_rail_sync.sv
module lam_rail_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lam_mark_qual.sv
module lam_mark_qual
  import line_mon_pkg::*;
#(
  parameter int unsigned MIN_WIDTH = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rail_t rail_i,
  output logic  mark_o
);
  localparam int unsigned TW = $clog2(MIN_WIDTH + 1);

  logic [NUM_MARK_TYPES-1:0] cond;
  logic [NUM_MARK_TYPES-1:0] hit;

  assign cond = mark_cond(rail_i);

  for (genvar t = 0; t < NUM_MARK_TYPES; t++) begin : g_type
    logic [TW-1:0] tmr_q;

    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                       tmr_q <= '0;
      else if (!cond[t])                 tmr_q <= '0;
      else if (tmr_q != TW'(MIN_WIDTH))  tmr_q <= tmr_q + 1'b1;

    // fires once, on the MIN_WIDTH-th consecutive clock of the condition
    assign hit[t] = cond[t] && (tmr_q == TW'(MIN_WIDTH - 1));

    if (MIN_WIDTH > 1) begin : g_chk
      assert_hit_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit[t] |-> $past(cond[t]));
    end
    assert_single_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit[t] |=> !hit[t]);
  end

  assign mark_o = |hit;

  assert_same_pol_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rail_i.c0_pos && rail_i.c1_pos) || (rail_i.c0_neg && rail_i.c1_neg)) |-> !mark_o);
endmodule

// File: rtl/lam_zero_run.sv
module lam_zero_run #(
  parameter int unsigned ZERO_LIMIT = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic mark_i,
  output logic loss_o
);
  localparam int unsigned CW  = $clog2(ZERO_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(ZERO_LIMIT);

  logic [CW-1:0] cnt_q, cnt_inc;
  logic          pend_q, loss_q, marked;

  assign marked  = pend_q | mark_i;
  assign cnt_inc = (cnt_q == LIM) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      loss_q <= 1'b0;
    end else if (bit_stb_i) begin
      pend_q <= 1'b0;
      if (marked) begin
        cnt_q  <= '0;
        loss_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_inc;
        loss_q <= (cnt_inc == LIM);
      end
    end else if (mark_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
    end

  assign loss_o = loss_q;

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  assert_hold_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loss_q && bit_stb_i && !marked) |=> loss_q);
  assert_rise_on_stb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loss_q) |-> $past(bit_stb_i));
  assert_fall_on_stb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(loss_q) |-> $past(bit_stb_i));
  assert_mark_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_i && !bit_stb_i) |=> (cnt_q == '0));
  assert_coincide_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_i && bit_stb_i) |=> (!loss_q && cnt_q == '0));
endmodule

// File: rtl/line_activity_mon.sv
module line_activity_mon
  import line_mon_pkg::*;
#(
  parameter int unsigned MIN_WIDTH   = 4,
  parameter int unsigned ZERO_LIMIT  = 63,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic c0_pos_i,
  input  logic c0_neg_i,
  input  logic c1_pos_i,
  input  logic c1_neg_i,
  output logic loss_o
);
  localparam int unsigned RW = $bits(rail_t);

  rail_t raw, rail_s;
  logic  mark;

  assign raw = '{c0_pos: c0_pos_i, c0_neg: c0_neg_i, c1_pos: c1_pos_i, c1_neg: c1_neg_i};

  lam_rail_sync #(.WIDTH(RW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (rail_s)
  );

  lam_mark_qual #(.MIN_WIDTH(MIN_WIDTH)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rail_i(rail_s),
    .mark_o(mark)
  );

  lam_zero_run #(.ZERO_LIMIT(ZERO_LIMIT)) u_zero (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bit_stb_i(bit_stb_i),
    .mark_i   (mark),
    .loss_o   (loss_o)
  );
endmodule

// File: tb/line_activity_mon_tb.sv
module line_activity_mon_tb;
  localparam int MINW = 4;
  localparam int LIM  = 63;
  localparam int SLOT = 8;

  logic clk = 0, rst_ni = 0, stb = 0;
  logic c0p = 0, c0n = 0, c1p = 0, c1n = 0;
  logic loss;
  int   tests = 0, fails = 0;
  bit   done = 0;
  string cur_req = "R10";

  always #2 clk = ~clk;

  line_activity_mon u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_stb_i(stb),
    .c0_pos_i(c0p), .c0_neg_i(c0n), .c1_pos_i(c1p), .c1_neg_i(c1n),
    .loss_o(loss)
  );

  // behavioural model: delay line, run lengths, zero count
  logic [3:0] d1, d2;
  int run_a, run_b, m_cnt;
  bit m_pend, m_flag;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      d1 = 0; d2 = 0; run_a = 0; run_b = 0; m_cnt = 0; m_pend = 0; m_flag = 0;
    end else begin
      bit ca, cb, q;
      ca = d2[3] && d2[0] && !d2[2] && !d2[1];
      cb = d2[2] && d2[1] && !d2[3] && !d2[0];
      q  = (ca && run_a == MINW-1) || (cb && run_b == MINW-1);
      run_a = ca ? ((run_a < MINW) ? run_a + 1 : run_a) : 0;
      run_b = cb ? ((run_b < MINW) ? run_b + 1 : run_b) : 0;
      if (stb) begin
        if (m_pend || q) begin m_cnt = 0; m_flag = 0; end
        else begin
          if (m_cnt < LIM) m_cnt++;
          m_flag = (m_cnt == LIM);
        end
        m_pend = 0;
      end else if (q) begin
        m_cnt = 0; m_pend = 1;
      end
      d2 = d1;
      d1 = {c0p, c0n, c1p, c1n};
    end
  end

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: loss_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_ni && !done) check({cur_req, " model"}, loss, m_flag);

  // kind: 0 idle, 1 type A, 2 type B, 3 same positive, 4 same negative, 5 all flags
  task automatic slot(int kind, int off, int w);
    for (int c = 0; c < SLOT; c++) begin
      @(negedge clk);
      stb = (c == SLOT-1);
      if (c >= off && c < off + w) begin
        c0p = (kind == 1 || kind == 3 || kind == 5);
        c0n = (kind == 2 || kind == 4 || kind == 5);
        c1p = (kind == 2 || kind == 3 || kind == 5);
        c1n = (kind == 1 || kind == 4 || kind == 5);
      end else begin
        c0p = 0; c0n = 0; c1p = 0; c1n = 0;
      end
    end
    @(negedge clk);
    stb = 0; c0p = 0; c0n = 0; c1p = 0; c1n = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) slot(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset", loss, 1'b0);
    rst_ni = 1;

    cur_req = "R5";
    idle(LIM - 1);  check("R5 after 62 zeros", loss, 1'b0);
    idle(1);        check("R5 after 63 zeros", loss, 1'b1);

    cur_req = "R6";
    idle(20);       check("R6 saturated", loss, 1'b1);

    cur_req = "R8";
    slot(1, 0, MINW); check("R1 R8 type A mark clears at strobe", loss, 1'b0);

    cur_req = "R7";
    idle(LIM - 1);  check("R7 62 zeros after mark", loss, 1'b0);
    idle(1);        check("R7 63 zeros after mark", loss, 1'b1);

    cur_req = "R2";
    slot(2, 0, MINW + 2); check("R2 type B mark", loss, 1'b0);

    cur_req = "R3";
    idle(LIM - 1);
    slot(1, 0, MINW - 1); check("R3 short A is a zero", loss, 1'b1);
    slot(2, 1, MINW - 1); check("R3 short B is a zero", loss, 1'b1);

    cur_req = "R4";
    slot(3, 0, 6); check("R4 both positive", loss, 1'b1);
    slot(4, 0, 6); check("R4 both negative", loss, 1'b1);
    slot(5, 0, 6); check("R4 all flags", loss, 1'b1);

    cur_req = "R9";
    slot(1, 2, MINW); check("R9 mark at strobe edge", loss, 1'b0);
    idle(LIM);        check("R9 re-armed", loss, 1'b1);
    slot(2, 3, MINW); check("R9 mark after strobe edge", loss, 1'b1);
    idle(1);          check("R9 late mark in next slot", loss, 1'b0);

    cur_req = "R10";
    idle(30);
    @(negedge clk); rst_ni = 0;
    @(negedge clk); check("R10 async reset", loss, 1'b0);
    rst_ni = 1;
    idle(LIM - 1);  check("R10 count cleared", loss, 1'b0);
    idle(1);        check("R10 recount", loss, 1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: finished=0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule